// File: doc/BRIEF.md
# Configurable Two-Plane Logic Array

This block is a sum-of-products logic array in which both the product plane and the sum plane are set by a configuration image. Every input gives each product term two taps, one for its true value and one for its inverted value. Each output gathers any subset of the product terms into an OR gate. A per-output XOR then decides whether the sum is delivered as-is or inverted.

The configuration is loaded serially, one bit per clock, while a load strobe is high. The bit that leaves the far end of the chain is visible on a readback pin, so shifting the image through a second time reproduces it for checking. Once loaded, the outputs follow the data inputs combinationally. No clock edge is needed for a new input pattern to reach the outputs.

Top module: `pla_array`

## Requirements
- R1: The configuration chain holds CFG_W = 2·N_IN·N_PT + N_PT·N_OUT + N_OUT bits. With `cfg_load` high, each rising edge shifts `cfg_in` into the chain, and the first bit shifted ends up at chain position 0. Stream index k maps to chain position k. Position (t·N_IN + i)·2 is the true tap of input i on product t, and the next position is its inverted tap. Position 2·N_IN·N_PT + o·N_PT + t selects product t into output o. Position 2·N_IN·N_PT + N_PT·N_OUT + o is the polarity bit of output o.
- R2: While `cfg_load` is low, the configuration and `cfg_out` do not change, whatever `cfg_in` does.
- R3: A product term is the AND of the literals it taps. A true tap contributes x_in[i], and an inverted tap contributes the inverse of x_in[i].
- R4: A product term that taps both the true and the inverted literal of the same input is constant 0.
- R5: A product term with no taps is 1. An output with no selected products is 0 before its polarity stage.
- R6: Each output before polarity is the OR of the product terms selected for it.
- R7: A polarity bit of 1 inverts its output, and 0 passes it unchanged.
- R8: A synchronous reset clears every configuration bit, so all outputs and `cfg_out` read 0.
- R9: `cfg_out` shows chain position 0. While shifting with `cfg_load` high, the bit of stream index k appears there after k further shift edges.
- R10: The outputs are combinational in `x_in`. They settle in the same cycle as an input change.
- R11: With 3 inputs, 4 products and 2 outputs, a suitable image yields F1 = A·B' + A·C + A'·B·C' and F2 = (A·C + B·C)', where A, B and C are x_in[0], x_in[1] and x_in[2].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | Shift enable for the configuration chain |
| cfg_in | input | 1 | Serial configuration data |
| cfg_out | output | 1 | Readback of chain position 0 |
| x_in | input | N_IN | Data inputs |
| y_out | output | N_OUT | Logic outputs |

## Verification
Data results are due with no clock delay. The bench changes `x_in` on a falling edge and samples `y_out` 1 ns later, within the same cycle. Configuration results take one rising edge per bit. The bench drives each bit on a falling edge, lets one rising edge pass, and compares `cfg_out` on the next falling edge against the image bit whose index equals the number of shifts made. Every configuration is swept over all eight input patterns, and each output is compared with a value computed from the image contents.

// File: rtl/pla_array.sv
module pla_array #(
  parameter int N_IN  = 3,
  parameter int N_PT  = 4,
  parameter int N_OUT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic             cfg_in,
  output logic             cfg_out,
  input  logic [N_IN-1:0]  x_in,
  output logic [N_OUT-1:0] y_out
);
  localparam int AND_W = 2 * N_IN * N_PT;
  localparam int OR_W  = N_PT * N_OUT;
  localparam int CFG_W = AND_W + OR_W + N_OUT;

  logic [CFG_W-1:0] chain;
  logic [N_PT-1:0][N_IN-1:0] tap_t, tap_c, lit_ok;
  logic [N_PT-1:0] prod;
  logic [N_OUT-1:0][N_PT-1:0] sel;
  logic [N_OUT-1:0] or_raw, pol;

  always_ff @(posedge clk) begin
    if (rst)           chain <= '0;
    else if (cfg_load) chain <= {chain[CFG_W-2:0], cfg_in};
  end

  assign cfg_out = chain[CFG_W-1];

  for (genvar t = 0; t < N_PT; t++) begin : g_pt
    for (genvar i = 0; i < N_IN; i++) begin : g_in
      assign tap_t[t][i]  = chain[CFG_W-1-(t*N_IN+i)*2];
      assign tap_c[t][i]  = chain[CFG_W-2-(t*N_IN+i)*2];
      assign lit_ok[t][i] = (~tap_t[t][i] | x_in[i]) & (~tap_c[t][i] | ~x_in[i]);
    end
    assign prod[t] = &lit_ok[t];

    assert_contradiction_R4: assert property (@(posedge clk) disable iff (rst)
      (|(tap_t[t] & tap_c[t])) |-> !prod[t]);
    assert_empty_product_R5: assert property (@(posedge clk) disable iff (rst)
      ((tap_t[t] | tap_c[t]) == '0) |-> prod[t]);
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    for (genvar t = 0; t < N_PT; t++) begin : g_sel
      assign sel[o][t] = chain[CFG_W-1-AND_W-o*N_PT-t];
    end
    assign pol[o]    = chain[CFG_W-1-AND_W-OR_W-o];
    assign or_raw[o] = |(prod & sel[o]);

    assert_empty_sum_R5: assert property (@(posedge clk) disable iff (rst)
      (sel[o] == '0) |-> (y_out[o] == pol[o]));
  end

  assign y_out = or_raw ^ pol;

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !cfg_load |=> $stable(cfg_out));
  assert_shift_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> (cfg_out == $past(chain[CFG_W-2])));
endmodule

// File: tb/pla_array_tb.sv
module pla_array_tb;
  localparam int NI = 3, NP = 4, NO = 2;
  localparam int CW = 2*NI*NP + NP*NO + NO;

  logic clk = 0, rst = 1, cfg_load = 0, cfg_in = 0;
  logic cfg_out;
  logic [NI-1:0] x_in = '0;
  logic [NO-1:0] y_out;

  int checks = 0, errors = 0;
  logic tt [NP][NI];
  logic tc [NP][NI];
  logic sl [NO][NP];
  logic pl [NO];
  logic img [CW];

  pla_array #(.N_IN(NI), .N_PT(NP), .N_OUT(NO)) u_dut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_in(cfg_in),
    .cfg_out(cfg_out), .x_in(x_in), .y_out(y_out));

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_cfg();
    for (int t = 0; t < NP; t++) begin
      for (int i = 0; i < NI; i++) begin tt[t][i] = 0; tc[t][i] = 0; end
      for (int o = 0; o < NO; o++) sl[o][t] = 0;
    end
    for (int o = 0; o < NO; o++) pl[o] = 0;
  endtask

  task automatic build_img();
    for (int t = 0; t < NP; t++)
      for (int i = 0; i < NI; i++) begin
        img[(t*NI+i)*2]   = tt[t][i];
        img[(t*NI+i)*2+1] = tc[t][i];
      end
    for (int o = 0; o < NO; o++) begin
      for (int t = 0; t < NP; t++) img[2*NI*NP + o*NP + t] = sl[o][t];
      img[2*NI*NP + NP*NO + o] = pl[o];
    end
  endtask

  function automatic logic [NO-1:0] model(input logic [NI-1:0] x);
    logic [NO-1:0] r;
    for (int o = 0; o < NO; o++) begin
      logic acc = 0;
      for (int t = 0; t < NP; t++) begin
        logic p = 1;
        for (int i = 0; i < NI; i++) begin
          if (tt[t][i] && !x[i]) p = 0;
          if (tc[t][i] && x[i])  p = 0;
        end
        if (sl[o][t] && p) acc = 1;
      end
      r[o] = acc ^ pl[o];
    end
    return r;
  endfunction

  task automatic load_img();
    build_img();
    for (int k = 0; k < CW; k++) begin
      @(negedge clk); cfg_load = 1; cfg_in = img[k];
    end
    @(negedge clk); cfg_load = 0; cfg_in = 0;
  endtask

  task automatic sweep(input string req);
    for (int v = 0; v < 8; v++) begin
      @(negedge clk); x_in = 3'(v); #1;
      check(req, 32'(y_out), 32'(model(3'(v))));
    end
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); #1;
    // R8: cleared configuration
    check("R8 y_out after reset", 32'(y_out), 0);
    check("R8 cfg_out after reset", 32'(cfg_out), 0);
    clear_cfg();
    sweep("R8 R5 empty config");

    // R11 R3 R6 R7 R10: reference functions
    clear_cfg();
    tt[0][0] = 1; tc[0][1] = 1;
    tt[1][0] = 1; tt[1][2] = 1;
    tc[2][0] = 1; tt[2][1] = 1; tc[2][2] = 1;
    tt[3][1] = 1; tt[3][2] = 1;
    sl[0][0] = 1; sl[0][1] = 1; sl[0][2] = 1;
    sl[1][1] = 1; sl[1][3] = 1; pl[1] = 1;
    load_img();
    for (int v = 0; v < 8; v++) begin
      logic a, b, c, f1, f2;
      a = v[0]; b = v[1]; c = v[2];
      f1 = (a & ~b) | (a & c) | (~a & b & ~c);
      f2 = ~((a & c) | (b & c));
      @(negedge clk); x_in = 3'(v); #1;
      check("R11 R10 F1", 32'(y_out[0]), 32'(f1));
      check("R11 R7 F2", 32'(y_out[1]), 32'(f2));
    end

    // R2: cfg_in toggling with load low changes nothing
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); cfg_in = ~cfg_in;
    end
    @(negedge clk); cfg_in = 0;
    check("R2 cfg_out held", 32'(cfg_out), 32'(img[0]));
    sweep("R2 outputs held");

    // R1 R9: readback of the image, then chain empty
    for (int k = 0; k < CW; k++) begin
      @(negedge clk);
      check("R9 R1 readback", 32'(cfg_out), 32'(img[k]));
      cfg_load = 1; cfg_in = 0;
    end
    @(negedge clk); cfg_load = 0; #1;
    check("R1 chain flushed", 32'(y_out), 0);

    // R4 R5: contradictory and empty products
    clear_cfg();
    tt[0][0] = 1; tc[0][0] = 1; sl[0][0] = 1;
    sl[1][1] = 1;
    load_img();
    sweep("R4 R5 contradiction and empty term");

    // R3 R6 R7: pseudo-random images
    for (int n = 0; n < 40; n++) begin
      for (int t = 0; t < NP; t++) begin
        for (int i = 0; i < NI; i++) begin
          tt[t][i] = (($urandom % 3) == 0);
          tc[t][i] = (($urandom % 3) == 0);
        end
        for (int o = 0; o < NO; o++) sl[o][t] = 1'($urandom);
      end
      for (int o = 0; o < NO; o++) pl[o] = 1'($urandom);
      load_img();
      sweep("R3 R6 R7 random image");
    end

    // R8: reset after a loaded image
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; #1;
    check("R8 cfg_out after reset", 32'(cfg_out), 0);
    clear_cfg();
    sweep("R8 outputs after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule